// File: doc/BRIEF.md
# I2S Master Audio Transmitter

This block sends 16-bit stereo audio over a three-wire I2S link as the link master. It runs from a fixed 12 MHz reference clock. From that clock it builds the serial bit clock and the word-select line for one of nine standard sample rates, chosen by a small code. A phase accumulator does the division, so rates that do not divide the reference evenly still come out right on average.

Once per stereo frame the transmitter asks its source for a new sample pair with a one-cycle request strobe. It takes the pair if the source marks it valid. It then shifts the left word and the right word out most significant bit first. Each word starts one bit clock after the word-select change, as I2S framing requires. If no sample is offered when a frame begins, the block sends silence and flags an underrun. Dropping the enable input parks all three link wires low and rewinds the framing, so the next frame starts on the left channel.

Top module: `i2s_master_tx`

## Requirements
- R1: SCK completes 32 periods per stereo frame, and WS completes one period per frame. Measured over four frames, the frame length in reference cycles matches REF_HZ/fs within 0.1 % plus 2 cycles.
- R2: `rate_sel` picks fs as follows: 0=8000, 1=11025, 2=12000, 3=16000, 4=22050, 5=24000, 6=32000, 7=44100, 8=48000 Hz. Codes 9 to 15 act as code 8.
- R3: Slot k is the k-th SCK period of a frame, with k from 0 to 31. WS is 0 in slots 0 to 15 and 1 in slots 16 to 31, so a frame always starts with WS low.
- R4: Slots 1 to 16 carry the left word and slots 17 to 31 plus slot 0 of the next frame carry the right word. Each word goes out MSB first, in two's complement and unaltered.
- R5: While enabled, SD and WS change only on the reference edge where SCK falls.
- R6: `s_ready` is a one-cycle pulse, given once per frame in the last reference cycle of slot 0, while SCK is high and WS is low. A sample pair is taken when `s_valid` is high in that cycle.
- R7: If `s_valid` is low during the `s_ready` pulse, `underrun` pulses in the same cycle and both words of that frame are sent as zero.
- R8: While `enable` is low, SCK, WS and SD are low. After enable, the first SCK rise falls in slot 0, with SD low and WS low.
- R9: After reset, SCK, WS, SD, `s_ready` and `underrun` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 12 MHz reference clock |
| rst_n | input | 1 | asynchronous active-low reset |
| enable | input | 1 | runs the link when high |
| rate_sel | input | 4 | sample-rate code |
| s_valid | input | 1 | source offers a sample pair |
| s_left | input | 16 | left-channel sample |
| s_right | input | 16 | right-channel sample |
| s_ready | output | 1 | one-cycle sample-request strobe |
| sck | output | 1 | serial bit clock |
| ws | output | 1 | word select, 0 = left |
| sd | output | 1 | serial data |
| underrun | output | 1 | pulses when a frame starts without a sample |

## Verification
A new SCK level, WS level or SD bit appears one reference cycle after the accumulator overflows, because each comes straight from a register. The bench therefore samples every output on the falling reference edge and treats an SCK rise as the point where the receiver reads SD and WS. `s_ready` and `underrun` are combinational, so they are sampled in the cycle before the transfer edge. The source updates its data on the falling reference edge after each handshake. Frame length is timed between WS falls over four frames. The tolerance covers one cycle of edge jitter at each end.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

  localparam int NUM_RATES = 9;

  // Sample rate in Hz for each selector code; codes past the table use the top rate.
  function automatic int unsigned rate_hz(input int code);
    case (code)
      0:       return 8000;
      1:       return 11025;
      2:       return 12000;
      3:       return 16000;
      4:       return 22050;
      5:       return 24000;
      6:       return 32000;
      7:       return 44100;
      default: return 48000;
    endcase
  endfunction

  // Phase increment: SCK edges per second are 2 edges * 2 channels * bits * fs.
  function automatic logic [63:0] phase_step(input logic [63:0] fs, input logic [63:0] ref_hz,
                                             input int accw, input int wbits);
    logic [63:0] num;
    num = (64'(4 * wbits) * fs) << accw;
    return (num + (ref_hz >> 1)) / ref_hz;
  endfunction

endpackage

// File: rtl/i2s_tx_clkgen.sv
module i2s_tx_clkgen
  import i2s_tx_pkg::*;
#(
  parameter int unsigned REF_HZ    = 12_000_000,
  parameter int          ACC_W     = 24,
  parameter int          WORD_BITS = 16,
  parameter int          SEL_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [SEL_W-1:0] rate_sel,
  output logic             sck,
  output logic             sck_fall
);

  logic [ACC_W-1:0] step_tab [NUM_RATES];

  for (genvar g = 0; g < NUM_RATES; g++) begin : g_step
    localparam logic [63:0] STEP = phase_step(64'(rate_hz(g)), 64'(REF_HZ), ACC_W, WORD_BITS);
    assign step_tab[g] = STEP[ACC_W-1:0];
  end

  logic [SEL_W-1:0] sel_idx;
  logic [ACC_W-1:0] step;
  logic [ACC_W:0]   acc_sum;
  logic [ACC_W-1:0] acc_q, acc_d;
  logic             sck_q, sck_d;
  logic             tick;

  always_comb begin
    sel_idx = (rate_sel < SEL_W'(NUM_RATES)) ? rate_sel : SEL_W'(NUM_RATES - 1);
    step    = step_tab[sel_idx];
    acc_sum = {1'b0, acc_q} + {1'b0, step};
    tick    = acc_sum[ACC_W];
    if (!enable) begin
      acc_d = '0;
      sck_d = 1'b0;
    end else begin
      acc_d = acc_sum[ACC_W-1:0];
      sck_d = tick ? ~sck_q : sck_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      sck_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      sck_q <= sck_d;
    end
  end

  assign sck      = sck_q;
  assign sck_fall = enable & tick & sck_q;

  // The increment stays below half the accumulator range, so every SCK level lasts at least two cycles.
  p_sck_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |=> $stable(sck));

  p_sck_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !sck);

endmodule

// File: rtl/i2s_tx_framer.sv
module i2s_tx_framer #(
  parameter int WORD_BITS = 16,
  localparam int SLOTS    = 2 * WORD_BITS,
  localparam int CNT_W    = $clog2(SLOTS)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic sck_fall,
  output logic ws,
  output logic load
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ws_q, ws_d;

  always_comb begin
    cnt_d = cnt_q;
    ws_d  = ws_q;
    if (!enable) begin
      cnt_d = '0;
      ws_d  = 1'b0;
    end else if (sck_fall) begin
      cnt_d = (cnt_q == CNT_W'(SLOTS - 1)) ? '0 : cnt_q + 1'b1;
      ws_d  = (cnt_d >= CNT_W'(WORD_BITS));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ws_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ws_q  <= ws_d;
    end
  end

  assign ws   = ws_q;
  assign load = sck_fall & (cnt_q == '0);

  p_ws_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && !$stable(ws)) |-> $past(sck_fall));

  p_ws_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !ws);

endmodule

// File: rtl/i2s_tx_shifter.sv
module i2s_tx_shifter #(
  parameter int WORD_BITS = 16,
  localparam int FRAME_W  = 2 * WORD_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic                 sck_fall,
  input  logic                 load,
  input  logic                 s_valid,
  input  logic [WORD_BITS-1:0] s_left,
  input  logic [WORD_BITS-1:0] s_right,
  output logic                 s_ready,
  output logic                 sd,
  output logic                 underrun
);

  logic [FRAME_W-1:0] shreg_q, shreg_d;

  always_comb begin
    shreg_d = shreg_q;
    if (!enable) begin
      shreg_d = '0;
    end else if (load) begin
      shreg_d = s_valid ? {s_left, s_right} : '0;
    end else if (sck_fall) begin
      shreg_d = {shreg_q[FRAME_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg_q <= '0;
    else        shreg_q <= shreg_d;
  end

  assign sd       = shreg_q[FRAME_W-1];
  assign s_ready  = load;
  assign underrun = load & ~s_valid;

  p_ready_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |=> !s_ready);

  p_underrun_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> !sd);

  p_sd_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && !$stable(sd)) |-> $past(sck_fall));

endmodule

// File: rtl/i2s_master_tx.sv
module i2s_master_tx #(
  parameter int unsigned REF_HZ    = 12_000_000,
  parameter int          ACC_W     = 24,
  parameter int          WORD_BITS = 16,
  parameter int          SEL_W     = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic [SEL_W-1:0]     rate_sel,
  input  logic                 s_valid,
  input  logic [WORD_BITS-1:0] s_left,
  input  logic [WORD_BITS-1:0] s_right,
  output logic                 s_ready,
  output logic                 sck,
  output logic                 ws,
  output logic                 sd,
  output logic                 underrun
);

  logic sck_fall;
  logic load;

  i2s_tx_clkgen #(
    .REF_HZ(REF_HZ), .ACC_W(ACC_W), .WORD_BITS(WORD_BITS), .SEL_W(SEL_W)
  ) u_clkgen (
    .clk(clk), .rst_n(rst_n), .enable(enable), .rate_sel(rate_sel),
    .sck(sck), .sck_fall(sck_fall)
  );

  i2s_tx_framer #(.WORD_BITS(WORD_BITS)) u_framer (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sck_fall(sck_fall),
    .ws(ws), .load(load)
  );

  i2s_tx_shifter #(.WORD_BITS(WORD_BITS)) u_shifter (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sck_fall(sck_fall), .load(load),
    .s_valid(s_valid), .s_left(s_left), .s_right(s_right),
    .s_ready(s_ready), .sd(sd), .underrun(underrun)
  );

  p_request_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (sck && !ws));

endmodule

// File: tb/i2s_master_tx_test.sv
module i2s_master_tx_test;

  localparam longint REF = 12_000_000;

  typedef struct packed {
    logic [3:0]  code;
    logic [31:0] hz;
  } vec_t;

  // Stimulus code with the sample rate the requirements assign to it.
  localparam vec_t VECS [10] = '{
    '{4'd0, 32'd8000},  '{4'd1, 32'd11025}, '{4'd2, 32'd12000}, '{4'd3, 32'd16000},
    '{4'd4, 32'd22050}, '{4'd5, 32'd24000}, '{4'd6, 32'd32000}, '{4'd7, 32'd44100},
    '{4'd8, 32'd48000}, '{4'd12, 32'd48000}
  };

  logic        clk = 1'b0;
  logic        rst_n, enable, s_valid;
  logic [3:0]  rate_sel;
  logic [15:0] s_left, s_right;
  logic        s_ready, sck, ws, sd, underrun;

  int          n_checks = 0;
  int          n_fail   = 0;
  int          run_id   = 0;
  int          pop_idx  = 0;
  bit          expect_zero = 1'b0;

  always #10 clk = ~clk;

  i2s_master_tx uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .rate_sel(rate_sel),
    .s_valid(s_valid), .s_left(s_left), .s_right(s_right),
    .s_ready(s_ready), .sck(sck), .ws(ws), .sd(sd), .underrun(underrun)
  );

  function automatic logic [31:0] gen(input int run, input int i);
    if (i == 0) return {16'h8000, 16'h7FFF};
    return {16'(run * 4099 + i * 771), 16'(16'hA5C3 ^ 16'(i * 2053 + run))};
  endfunction

  logic [31:0] cur;
  assign cur     = gen(run_id, pop_idx);
  assign s_left  = cur[31:16];
  assign s_right = cur[15:0];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Receiver model: samples on the falling reference edge, reads SD/WS at SCK rises.
  logic        p_sck = 0, p_ws = 0, p_sd = 0, p_en = 0;
  longint      cyc = 0;
  int          nrise, nfall, frames_ok, frames_bad, ws_bad, edge_bad;
  int          ready_bad, n_ready, n_under, s0_bad;
  logic [31:0] word, last_got, last_exp;
  longint      t_fall [8];

  always @(negedge clk) begin
    cyc++;
    if (enable && rst_n) begin
      if (s_ready) begin
        n_ready++;
        if ((nrise % 32) != 1 || ws || !sck) ready_bad++;
      end
      if (underrun) n_under++;
      if (p_en && (ws != p_ws || sd != p_sd) && !(p_sck && !sck)) edge_bad++;
      if (sck && !p_sck) begin
        if (ws != ((nrise % 32) >= 16)) ws_bad++;
        if (nrise == 0 && (sd || ws)) s0_bad++;
        word = {word[30:0], sd};
        if (nrise > 0 && (nrise % 32) == 0) begin
          last_exp = expect_zero ? 32'h0 : gen(run_id, nrise / 32 - 1);
          if (word == last_exp) frames_ok++;
          else begin frames_bad++; last_got = word; end
        end
        nrise++;
      end
      if (!ws && p_ws) begin
        if (nfall < 8) t_fall[nfall] = cyc;
        nfall++;
      end
    end else begin
      nrise = 0; nfall = 0; frames_ok = 0; frames_bad = 0; ws_bad = 0;
      edge_bad = 0; ready_bad = 0; n_ready = 0; n_under = 0; s0_bad = 0;
      word = '0; last_got = '0; last_exp = '0;
    end
    p_sck = sck; p_ws = ws; p_sd = sd; p_en = enable && rst_n;
  end

  task automatic run_rate(input logic [3:0] code, input longint fs, input bit zero);
    bit     pop_next;
    longint meas, diff, tol;
    enable = 1'b0;
    repeat (4) @(negedge clk);
    run_id++;
    pop_idx     = 0;
    rate_sel    = code;
    s_valid     = !zero;
    expect_zero = zero;
    pop_next    = 1'b0;
    enable      = 1'b1;
    while (nfall < 5 || frames_ok + frames_bad < 4) begin
      @(negedge clk);
      if (pop_next) begin pop_idx++; pop_next = 1'b0; end
      if (s_ready && s_valid) pop_next = 1'b1;
    end
    meas = t_fall[4] - t_fall[0];
    diff = meas * fs - 4 * REF;
    if (diff < 0) diff = -diff;
    tol = 2 * fs + (4 * REF) / 1000;
    check(diff <= tol, "R1 R2", $sformatf("frame length code %0d", code), meas, (4 * REF) / fs);
    check(frames_bad == 0 && frames_ok >= 4, "R4", $sformatf("serial words code %0d", code),
          longint'(last_got), longint'(last_exp));
    check(ws_bad == 0, "R3", "WS level per slot", ws_bad, 0);
    check(edge_bad == 0, "R5", "SD/WS change off SCK fall", edge_bad, 0);
    check(ready_bad == 0 && n_ready >= 4, "R6", "request strobe slot", ready_bad, 0);
    check(s0_bad == 0, "R8", "first slot after enable", s0_bad, 0);
    if (zero) check(n_under == n_ready && n_under >= 4, "R7", "underrun pulses", n_under, n_ready);
    else      check(n_under == 0, "R7", "no underrun with data", n_under, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks + 1);
    $finish;
  end

  initial begin
    int quiet;
    rst_n = 1'b0; enable = 1'b0; s_valid = 1'b0; rate_sel = 4'd0;
    repeat (3) @(negedge clk);
    check({sck, ws, sd, s_ready, underrun} == 5'b0, "R9", "outputs in reset",
          {sck, ws, sd, s_ready, underrun}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check({sck, ws, sd, s_ready, underrun} == 5'b0, "R9", "outputs after reset",
          {sck, ws, sd, s_ready, underrun}, 0);

    for (int i = 0; i < 10; i++) run_rate(VECS[i].code, longint'(VECS[i].hz), 1'b0);

    // Underrun: no sample ever offered
    run_rate(4'd8, 48000, 1'b1);

    // Disabled link stays quiet
    enable = 1'b0;
    quiet = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (sck || ws || sd) quiet++;
    end
    check(quiet == 0, "R8", "link low while disabled", quiet, 0);

    // Re-enable mid-way after a short run at another rate
    run_rate(4'd7, 44100, 1'b0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule